// File: doc/BRIEF.md
# Reversible Full Adder with Inverse-and-Compare Error Detection

This block computes a one-bit full addition with a chain of reversible gates working on four lines: operand A, operand B, carry-in, and a constant-zero ancilla. Two forward Peres-type gates leave the sum on the carry-in line and the carry-out on the ancilla line. Both results are copied out through CNOT gates whose targets are constant-zero lines, so no wire is fanned out directly. The same four lines then pass through the two gates in reverse order, each replaced by its exact inverse. Because every gate is a bijection, a healthy chain gives back the original A, B and carry-in, and a zero on the ancilla line. A comparator checks the four regenerated lines against those values and raises an error flag on any difference. A single flipped line is caught, and so is any pattern of flipped lines confined to one stage boundary.

A fault vector can invert any line at three cut points in the chain: after the first forward gate, after the second forward gate, and after the first inverse gate. This lets the detection path be tested on purpose. Sum, carry-out and the error flag are registered once. The registers load only while the enable is high. The output registers use a reset that asserts asynchronously and is released through a two-stage synchronizer.

Top module: `icd_rfa_top`

## Requirements
- R1: With no fault, ancilla input 0 and `en` high at a rising edge, `sum_o` after that edge equals A xor B xor carry-in.
- R2: Under the same conditions, `cout_o` after that edge is 1 exactly when at least two of A, B and carry-in are 1.
- R3: Under the same conditions, `err_o` after that edge is 0 for all eight input combinations.
- R4: Bit 4*k+j of `fault_i` inverts line j at cut k. Lines are 0=A, 1=B, 2=carry-in/sum, 3=ancilla/carry-out. Cuts are 0=after forward gate one, 1=after forward gate two, 2=after inverse gate two. Any nonzero fault pattern whose set bits all lie in one cut makes `err_o` 1 after the capturing edge.
- R5: With `anc_i` at 1 and no fault, `err_o` is 1 after the capturing edge.
- R6: Faults confined to cut 2 leave `sum_o` and `cout_o` equal to their fault-free values.
- R7: For faults confined to cut 1, `sum_o` is inverted exactly when bit 6 is set and `cout_o` exactly when bit 7 is set. Bits 4 and 5 leave both outputs unchanged.
- R8: While `en` is low, `sum_o`, `cout_o` and `err_o` keep their values whatever the other inputs do.
- R9: Driving `rst_n` low clears all three outputs at once without waiting for a clock. After `rst_n` rises, the outputs stay 0 and do not load for two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| en | input | 1 | Output register load enable |
| a_i | input | 1 | Operand A |
| b_i | input | 1 | Operand B |
| cin_i | input | 1 | Carry-in |
| anc_i | input | 1 | Ancilla line, 0 in normal use |
| fault_i | input | 12 | Line inversion mask, three cuts of four lines |
| sum_o | output | 1 | Registered sum |
| cout_o | output | 1 | Registered carry-out |
| err_o | output | 1 | Registered mismatch flag |

## Verification
The hardest case to reach is a fault that only the inverse half sees. A flip at cut 2 leaves sum and carry-out correct, so only the regenerated lines show it. The bench drives every single-line and multi-line mask at each cut directly through `fault_i`, across all input combinations. For each cut it checks separately whether the outputs must stay clean or must invert, while the flag must still rise.

// File: rtl/icd_rfa_pkg.sv
package icd_rfa_pkg;
  localparam int LINES     = 4;
  localparam int CUTS      = 3;
  localparam int FAULT_W   = LINES * CUTS;
  localparam int LN_A      = 0;
  localparam int LN_B      = 1;
  localparam int LN_CIN    = 2;
  localparam int LN_ANC    = 3;
  localparam int PRIM_W    = LINES - 1;
  typedef logic [LINES-1:0] lines_t;
endpackage

// File: rtl/icd_peres_gate.sv
module icd_peres_gate #(
  parameter int N       = 4,
  parameter int IA      = 0,
  parameter int IB      = 1,
  parameter int IC      = 3,
  parameter bit INVERSE = 1'b0
) (
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  if (!INVERSE) begin : g_fwd
    always_comb begin
      q_o     = d_i;
      q_o[IB] = d_i[IA] ^ d_i[IB];
      q_o[IC] = d_i[IC] ^ (d_i[IA] & d_i[IB]);
    end
  end else begin : g_inv
    always_comb begin
      q_o     = d_i;
      q_o[IB] = d_i[IB] ^ d_i[IA];
      q_o[IC] = d_i[IC] ^ (d_i[IA] & (d_i[IB] ^ d_i[IA]));
    end
  end
endmodule

// File: rtl/icd_fault_cut.sv
module icd_fault_cut #(
  parameter int N = 4
) (
  input  logic [N-1:0] d_i,
  input  logic [N-1:0] flip_i,
  output logic [N-1:0] q_o
);
  assign q_o = d_i ^ flip_i;
endmodule

// File: rtl/icd_regen_cmp.sv
module icd_regen_cmp #(
  parameter int N      = 4,
  parameter int PRIM_W = 3
) (
  input  logic [N-1:0]      regen_i,
  input  logic [PRIM_W-1:0] prim_i,
  output logic              err_o
);
  localparam int ZERO_W = N - PRIM_W;
  logic [N-1:0] expect_v;
  assign expect_v = {{ZERO_W{1'b0}}, prim_i};
  assign err_o    = |(regen_i ^ expect_v);
endmodule

// File: rtl/icd_rfa_top.sv
module icd_rfa_top
  import icd_rfa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               a_i,
  input  logic               b_i,
  input  logic               cin_i,
  input  logic               anc_i,
  input  logic [FAULT_W-1:0] fault_i,
  output logic               sum_o,
  output logic               cout_o,
  output logic               err_o
);
  // reset release synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  // line vectors along the chain
  lines_t s_in;
  lines_t s_regen;
  lines_t pre_cut  [CUTS];
  lines_t post_cut [CUTS];

  assign s_in = {anc_i, cin_i, b_i, a_i};

  for (genvar k = 0; k < CUTS; k++) begin : g_cut
    icd_fault_cut #(.N(LINES)) u_cut (
      .d_i    (pre_cut[k]),
      .flip_i (fault_i[k*LINES +: LINES]),
      .q_o    (post_cut[k])
    );
  end

  // forward half
  icd_peres_gate #(.N(LINES), .IA(LN_A), .IB(LN_B), .IC(LN_ANC), .INVERSE(1'b0)) u_fwd1 (
    .d_i (s_in),
    .q_o (pre_cut[0])
  );
  icd_peres_gate #(.N(LINES), .IA(LN_B), .IB(LN_CIN), .IC(LN_ANC), .INVERSE(1'b0)) u_fwd2 (
    .d_i (post_cut[0]),
    .q_o (pre_cut[1])
  );

  // CNOT copy points onto constant-zero targets
  logic copy_tgt_sum, copy_tgt_cout;
  logic sum_c, cout_c, err_c;
  assign copy_tgt_sum  = 1'b0;
  assign copy_tgt_cout = 1'b0;
  assign sum_c  = copy_tgt_sum  ^ post_cut[1][LN_CIN];
  assign cout_c = copy_tgt_cout ^ post_cut[1][LN_ANC];

  // inverse half, gates in reverse order
  icd_peres_gate #(.N(LINES), .IA(LN_B), .IB(LN_CIN), .IC(LN_ANC), .INVERSE(1'b1)) u_inv2 (
    .d_i (post_cut[1]),
    .q_o (pre_cut[2])
  );
  icd_peres_gate #(.N(LINES), .IA(LN_A), .IB(LN_B), .IC(LN_ANC), .INVERSE(1'b1)) u_inv1 (
    .d_i (post_cut[2]),
    .q_o (s_regen)
  );

  icd_regen_cmp #(.N(LINES), .PRIM_W(PRIM_W)) u_cmp (
    .regen_i (s_regen),
    .prim_i  (s_in[PRIM_W-1:0]),
    .err_o   (err_c)
  );

  // output register: next-state and storage kept apart
  logic [2:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (en) out_d = {sum_c, cout_c, err_c};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= '0;
    else             out_q <= out_d;
  end

  assign sum_o  = out_q[2];
  assign cout_o = out_q[1];
  assign err_o  = out_q[0];
endmodule

// File: rtl/icd_rfa_chk.sv
module icd_rfa_chk
  import icd_rfa_pkg::*;
(
  input logic               clk,
  input logic               rst_sync_n,
  input logic               en,
  input logic               a_i,
  input logic               b_i,
  input logic               cin_i,
  input logic               anc_i,
  input logic [FAULT_W-1:0] fault_i,
  input logic               sum_o,
  input logic               cout_o,
  input logic               err_o
);
  logic [CUTS-1:0] cut_hit;
  logic            clean;
  logic            late_only;
  logic            maj;

  always_comb begin
    for (int k = 0; k < CUTS; k++) cut_hit[k] = |fault_i[k*LINES +: LINES];
  end
  assign clean     = (fault_i == '0) && !anc_i;
  assign late_only = !anc_i && (cut_hit == 3'b100);
  assign maj       = (a_i & b_i) | (a_i & cin_i) | (b_i & cin_i);

  AST_CLEAN_SUM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && clean) |=> (sum_o == $past(a_i ^ b_i ^ cin_i))); // R1
  AST_CLEAN_CARRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && clean) |=> (cout_o == $past(maj))); // R2
  AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && clean) |=> !err_o); // R3
  AST_ONE_CUT_DETECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && !anc_i && $countones(cut_hit) == 1) |=> err_o); // R4
  AST_ANCILLA_DETECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && anc_i && fault_i == '0) |=> err_o); // R5
  AST_LATE_CUT_CLEAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && late_only) |=> (sum_o == $past(a_i ^ b_i ^ cin_i) && cout_o == $past(maj))); // R6
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> $stable({sum_o, cout_o, err_o})); // R8
endmodule

bind icd_rfa_top icd_rfa_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .en         (en),
  .a_i        (a_i),
  .b_i        (b_i),
  .cin_i      (cin_i),
  .anc_i      (anc_i),
  .fault_i    (fault_i),
  .sum_o      (sum_o),
  .cout_o     (cout_o),
  .err_o      (err_o)
);

// File: tb/icd_rfa_top_tb_top.sv
module icd_rfa_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic        a_i, b_i, cin_i, anc_i;
  logic [11:0] fault_i;
  logic        sum_o, cout_o, err_o;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  icd_rfa_top dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .anc_i(anc_i),
    .fault_i(fault_i),
    .sum_o(sum_o), .cout_o(cout_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b (a=%0b b=%0b cin=%0b anc=%0b fault=%03h)",
               req, act, exp, a_i, b_i, cin_i, anc_i, fault_i);
    end
  endtask

  // drive at a falling edge, output is registered at the next rising edge
  task automatic apply(input logic [2:0] v, input logic anc, input logic [11:0] m);
    a_i = v[0]; b_i = v[1]; cin_i = v[2]; anc_i = anc; fault_i = m; en = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic ref_sum(input logic [2:0] v);
    return v[0] ^ v[1] ^ v[2];
  endfunction
  function automatic logic ref_cout(input logic [2:0] v);
    int n;
    n = int'(v[0]) + int'(v[1]) + int'(v[2]);
    return n >= 2;
  endfunction

  initial begin
    rst_n = 1'b0; en = 1'b0; a_i = 0; b_i = 0; cin_i = 0; anc_i = 0; fault_i = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset sum", sum_o, 1'b0);
    chk("R9 reset err", err_o, 1'b0);
    rst_n = 1'b1;
    // load attempt during synchronized release window must not land
    a_i = 1'b1; en = 1'b1;
    @(negedge clk);
    chk("R9 release window sum", sum_o, 1'b0);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // fault-free arithmetic
    for (int i = 0; i < 8; i++) begin
      apply(3'(i), 1'b0, '0);
      chk("R1 sum", sum_o, ref_sum(3'(i)));
      chk("R2 cout", cout_o, ref_cout(3'(i)));
      chk("R3 no err", err_o, 1'b0);
    end

    // single-line flips at every cut
    for (int c = 0; c < 3; c++) begin
      for (int w = 0; w < 4; w++) begin
        for (int i = 0; i < 8; i++) begin
          apply(3'(i), 1'b0, 12'(1) << (c * 4 + w));
          chk("R4 single flip err", err_o, 1'b1);
          if (c == 2) begin
            chk("R6 late cut sum", sum_o, ref_sum(3'(i)));
            chk("R6 late cut cout", cout_o, ref_cout(3'(i)));
          end else if (c == 1) begin
            chk("R7 mid cut sum", sum_o, ref_sum(3'(i)) ^ (w == 2));
            chk("R7 mid cut cout", cout_o, ref_cout(3'(i)) ^ (w == 3));
          end
        end
      end
    end

    // multi-line patterns confined to one cut
    for (int c = 0; c < 3; c++) begin
      for (int m = 1; m < 16; m++) begin
        logic [2:0] v;
        logic [3:0] mm;
        v  = 3'((m * 5 + c) % 8);
        mm = 4'(m);
        apply(v, 1'b0, 12'(m) << (c * 4));
        chk("R4 multi flip err", err_o, 1'b1);
        if (c == 2) begin
          chk("R6 late cut multi sum", sum_o, ref_sum(v));
          chk("R6 late cut multi cout", cout_o, ref_cout(v));
        end else if (c == 1) begin
          chk("R7 mid cut multi sum", sum_o, ref_sum(v) ^ mm[2]);
          chk("R7 mid cut multi cout", cout_o, ref_cout(v) ^ mm[3]);
        end
      end
    end

    // ancilla driven high
    for (int i = 0; i < 8; i++) begin
      apply(3'(i), 1'b1, '0);
      chk("R5 ancilla err", err_o, 1'b1);
    end

    // hold with enable low
    apply(3'b011, 1'b0, '0);
    chk("R8 preload cout", cout_o, 1'b1);
    en = 1'b0; a_i = 0; b_i = 0; cin_i = 1; fault_i = 12'h001;
    @(negedge clk);
    @(negedge clk);
    chk("R8 hold sum", sum_o, 1'b0);
    chk("R8 hold cout", cout_o, 1'b1);
    chk("R8 hold err", err_o, 1'b0);

    // asynchronous reset assertion mid-cycle
    apply(3'b111, 1'b1, '0);
    chk("R9 preload err", err_o, 1'b1);
    #5 rst_n = 1'b0;
    #1;
    chk("R9 async clear sum", sum_o, 1'b0);
    chk("R9 async clear err", err_o, 1'b0);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(3'b101, 1'b0, '0);
    chk("R1 after reset sum", sum_o, 1'b0);
    chk("R2 after reset cout", cout_o, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule